// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block holds the floating-point control register of an execution core. That register has three parts: sticky exception status bits, per-exception trap-disable bits, and an underflow-to-zero mode bit. Each cycle a retiring instruction may present its exception flags and a trap-enable qualifier. Every flag that is raised lands in the sticky status, whatever the trap settings are. A flag is forwarded to the trap path only when two things hold: the instruction asked for traps, and the register does not disable that exception.

Trapping exceptions are ORed into a separate exception summary register. This register is cleared only by a dedicated clear input. A single-cycle trap request pulse goes to the core. When an operand-class condition and a result-class condition arrive together, the trap path sees only the operand-class condition. Software rewrites the whole control register through a write port, and that is the only way the status bits ever drop.

Top module: `fpx_trap_unit`

## Requirements
- R1: After synchronous active-low reset, `ctl_o`, `sum_o` and `trap_o` are all zero.
- R2: Flag bit positions are: 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 denormal input. A valid retirement ORs its flags into `ctl_o[5:0]` on the next cycle, whether `ret_trap_en_i` or the disable bits are set or clear.
- R3: Status bits never clear except by a register write. Flags presented while `ret_valid_i` is low leave `ctl_o` unchanged.
- R4: A write loads `ctl_o[5:0]` from `wr_data_i[5:0]` and `ctl_o[13:8]` from `wr_data_i[13:8]`. It takes priority over a retirement in the same cycle, so that retirement's flags are not added to status.
- R5: `ctl_o[6]` equals the OR of `ctl_o[5:0]` at all times. `ctl_o[7]` and `ctl_o[15]` always read zero.
- R6: After a write, `ctl_o[14]` (underflow-to-zero) is `wr_data_i[14] | wr_data_i[11]`. Whenever underflow-disable `ctl_o[11]` is set, `ctl_o[14]` is also set.
- R7: An exception takes part in a trap only if the retirement is valid, `ret_trap_en_i` is high, and its disable bit `ctl_o[8+i]` (as held before that cycle's write) is clear.
- R8: If any operand-class flag (bits 0, 1, 5) is set in a retirement, the result-class flags (bits 2, 3, 4) of that retirement do not reach `sum_o` or `trap_o`.
- R9: `sum_o` accumulates trapping exceptions by OR. `sum_clr_i` clears it, and any trapping exception in the same cycle as the clear is kept.
- R10: `trap_o` is high for exactly the one cycle after a retirement with at least one trapping exception, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid_i | input | 1 | A retirement is presented this cycle |
| ret_flags_i | input | 6 | Exception flags of the retiring instruction |
| ret_trap_en_i | input | 1 | Instruction requests trapping |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 16 | Control register write value |
| sum_clr_i | input | 1 | Clear the exception summary register |
| ctl_o | output | 16 | Control register contents |
| sum_o | output | 6 | Exception summary register |
| trap_o | output | 1 | One-cycle arithmetic trap request |

## Verification
Random retirements are run with sparse flag vectors, random trap qualifiers, and occasional writes and summary clears. This separates the ungated status path from the gated trap path: a disable bit or a low qualifier must change `sum_o` and `trap_o` but never the status. Directed cases put an operand-class flag together with result-class flags, so a missing precedence mask shows up in `sum_o`. Further directed cases cover a write colliding with a retirement, where the write must win, and a clear colliding with a new trap, where the new bits must survive. A write of underflow-disable alone exposes a missing underflow-to-zero implication.

// File: rtl/fpx_pkg.sv
// Package: shared widths, flag positions and register field offsets for
// the floating-point exception status and trap unit.
package fpx_pkg;
    localparam int EXC_W   = 6;   // number of exception kinds
    localparam int CTL_W   = 16;  // control register width
    // flag bit positions
    localparam int EX_INV  = 0;
    localparam int EX_DZE  = 1;
    localparam int EX_OVF  = 2;
    localparam int EX_UNF  = 3;
    localparam int EX_INX  = 4;
    localparam int EX_DNI  = 5;
    // control register field offsets
    localparam int STAT_LO = 0;
    localparam int SUM_BIT = STAT_LO + EXC_W;
    localparam int DIS_LO  = 8;
    localparam int UTZ_BIT = DIS_LO + EXC_W;
    // operand-class conditions outrank result-class ones
    localparam logic [EXC_W-1:0] OPND_CLASS =
        (EXC_W'(1) << EX_INV) | (EXC_W'(1) << EX_DZE) | (EXC_W'(1) << EX_DNI);
endpackage

// File: rtl/fpx_ctl_reg.sv
// Module: control register holding sticky status, trap disables and the
// underflow-to-zero bit. Assumes writes replace all fields and outrank a
// retirement arriving in the same cycle. Status only drops on a write.
module fpx_ctl_reg
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid_i,
    input  logic [EXC_W-1:0] ret_flags_i,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [EXC_W-1:0] dis_o
);
    logic [EXC_W-1:0] status_q;
    logic [EXC_W-1:0] dis_q;
    logic             utz_q;

    // One sticky flop per exception kind
    for (genvar i = 0; i < EXC_W; i++) begin : g_stat
        // Load on write, else set on a valid raised flag, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[i] <= 1'b0;
            else if (wr_en_i)
                status_q[i] <= wr_data_i[STAT_LO + i];
            else if (ret_valid_i && ret_flags_i[i])
                status_q[i] <= 1'b1;
        end
    end

    // Disable bits and the underflow-to-zero mode change only on writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= '0;
            utz_q <= 1'b0;
        end else if (wr_en_i) begin
            dis_q <= wr_data_i[DIS_LO +: EXC_W];
            utz_q <= wr_data_i[UTZ_BIT] | wr_data_i[DIS_LO + EX_UNF];
        end
    end

    // Assemble the visible register image; unused bits read zero
    always_comb begin
        ctl_o                    = '0;
        ctl_o[STAT_LO +: EXC_W]  = status_q;
        ctl_o[SUM_BIT]           = |status_q;
        ctl_o[DIS_LO +: EXC_W]   = dis_q;
        ctl_o[UTZ_BIT]           = utz_q;
    end

    assign dis_o = dis_q;

    // R2
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && !wr_en_i) |=> ((status_q & $past(ret_flags_i)) == $past(ret_flags_i)));
    // R3
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((status_q & $past(status_q)) == $past(status_q)));
    // R4
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (status_q == $past(wr_data_i[STAT_LO +: EXC_W])));
    // R6
    utz_imply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q[EX_UNF] |-> utz_q);
endmodule

// File: rtl/fpx_trap_sel.sv
// Module: combinational trap qualifier. Applies operand-over-result
// precedence, the instruction enable and the register disables to the
// retiring flags. Assumes disables are the values held before any write.
module fpx_trap_sel
    import fpx_pkg::*;
(
    input  logic             ret_valid_i,
    input  logic [EXC_W-1:0] ret_flags_i,
    input  logic             ret_trap_en_i,
    input  logic [EXC_W-1:0] dis_i,
    output logic [EXC_W-1:0] cand_o
);
    logic             opnd_hit;
    logic [EXC_W-1:0] filt;

    // Detect any operand-class condition in this retirement
    assign opnd_hit = |(ret_flags_i & OPND_CLASS);

    // Per-bit filter: result-class bits suppressed when an operand hit exists
    for (genvar i = 0; i < EXC_W; i++) begin : g_filt
        if (OPND_CLASS[i]) begin : g_op
            assign filt[i] = ret_flags_i[i];
        end else begin : g_res
            assign filt[i] = ret_flags_i[i] & ~opnd_hit;
        end
    end

    // Gate with validity, instruction enable and register disables
    always_comb begin
        cand_o = '0;
        if (ret_valid_i && ret_trap_en_i)
            cand_o = filt & ~dis_i;
    end
endmodule

// File: rtl/fpx_sum_reg.sv
// Module: exception summary register and trap pulse. Accumulates trapping
// exceptions by OR until cleared; a same-cycle new trap survives a clear.
module fpx_sum_reg
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXC_W-1:0] cand_i,
    input  logic             sum_clr_i,
    output logic [EXC_W-1:0] sum_o,
    output logic             trap_o
);
    logic [EXC_W-1:0] sum_q;
    logic             trap_q;

    // Accumulate trapping exceptions, clearing old content on request
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else
            sum_q <= (sum_clr_i ? '0 : sum_q) | cand_i;
    end

    // Raise the trap request for one cycle per trapping retirement
    always_ff @(posedge clk) begin
        if (!rst_n)
            trap_q <= 1'b0;
        else
            trap_q <= |cand_i;
    end

    assign sum_o  = sum_q;
    assign trap_o = trap_q;

    // R9
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_clr_i |=> ((sum_q & $past(sum_q)) == $past(sum_q)));
    // R10
    trap_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (sum_q != '0));
endmodule

// File: rtl/fpx_trap_unit.sv
// Module: top of the floating-point exception status and trap unit.
// Connects the control register, the trap qualifier and the summary
// register. Assumes one retirement per cycle at most.
module fpx_trap_unit
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid_i,
    input  logic [5:0]       ret_flags_i,
    input  logic             ret_trap_en_i,
    input  logic             wr_en_i,
    input  logic [15:0]      wr_data_i,
    input  logic             sum_clr_i,
    output logic [15:0]      ctl_o,
    output logic [5:0]       sum_o,
    output logic             trap_o
);
    logic [EXC_W-1:0] dis_w;
    logic [EXC_W-1:0] cand_w;

    fpx_ctl_reg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ret_valid_i (ret_valid_i),
        .ret_flags_i (ret_flags_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .ctl_o       (ctl_o),
        .dis_o       (dis_w)
    );

    fpx_trap_sel u_sel (
        .ret_valid_i   (ret_valid_i),
        .ret_flags_i   (ret_flags_i),
        .ret_trap_en_i (ret_trap_en_i),
        .dis_i         (dis_w),
        .cand_o        (cand_w)
    );

    fpx_sum_reg u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_i    (cand_w),
        .sum_clr_i (sum_clr_i),
        .sum_o     (sum_o),
        .trap_o    (trap_o)
    );

    // R5
    sum_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[SUM_BIT] == (|ctl_o[STAT_LO +: EXC_W]));
    // R7
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(ret_valid_i && ret_trap_en_i));
    // R8
    prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && |(ret_flags_i & OPND_CLASS)) |-> ((cand_w & ~OPND_CLASS) == '0));
endmodule

// File: tb/sim_fpx_trap_unit.sv
module sim_fpx_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ret_valid_i;
    logic [5:0]  ret_flags_i;
    logic        ret_trap_en_i;
    logic        wr_en_i;
    logic [15:0] wr_data_i;
    logic        sum_clr_i;
    logic [15:0] ctl_o;
    logic [5:0]  sum_o;
    logic        trap_o;

    int nvec  = 0;
    int nfail = 0;
    logic [15:0] m_ctl;
    logic [5:0]  m_sum;
    logic        m_trap;
    int unsigned seed_dummy;

    always #10 clk = ~clk;

    fpx_trap_unit u0 (.*);

    localparam logic [5:0] OPND = 6'b100011;

    function automatic logic [15:0] f_ctl(logic [15:0] c, logic v, logic [5:0] f,
                                          logic w, logic [15:0] d);
        logic [5:0] st; logic [5:0] ds; logic uz;
        st = c[5:0]; ds = c[13:8]; uz = c[14];
        if (w) begin
            st = d[5:0]; ds = d[13:8]; uz = d[14] | d[11];
        end else if (v) begin
            st = st | f;
        end
        return {1'b0, uz, ds, 1'b0, |st, st};
    endfunction

    function automatic logic [5:0] f_cand(logic [15:0] c, logic v, logic [5:0] f, logic te);
        logic [5:0] fl;
        fl = ((f & OPND) != 0) ? (f & OPND) : f;
        return (v && te) ? (fl & ~c[13:8]) : 6'b0;
    endfunction

    task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(string tag, logic v, logic [5:0] f, logic te,
                        logic w, logic [15:0] d, logic clr);
        logic [5:0] cd;
        @(negedge clk);
        ret_valid_i = v; ret_flags_i = f; ret_trap_en_i = te;
        wr_en_i = w; wr_data_i = d; sum_clr_i = clr;
        cd     = f_cand(m_ctl, v, f, te);
        m_ctl  = f_ctl(m_ctl, v, f, w, d);
        m_sum  = (clr ? 6'b0 : m_sum) | cd;
        m_trap = |cd;
        @(posedge clk); #1;
        chk(tag, "ctl", ctl_o, m_ctl);
        chk(tag, "sum", {10'b0, sum_o}, {10'b0, m_sum});
        chk(tag, "trap", {15'b0, trap_o}, {15'b0, m_trap});
    endtask

    initial begin
        #3_000_000;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5eed_1234);
        rst_n = 1'b0; ret_valid_i = 0; ret_flags_i = 0; ret_trap_en_i = 0;
        wr_en_i = 0; wr_data_i = 0; sum_clr_i = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "ctl", ctl_o, 16'h0);
        chk("R1", "sum", {10'b0, sum_o}, 16'h0);
        chk("R1", "trap", {15'b0, trap_o}, 16'h0);
        @(negedge clk); rst_n = 1'b1;
        m_ctl = 0; m_sum = 0; m_trap = 0;

        // R2 status set with trap disabled by the instruction
        step("R2", 1, 6'b010000, 0, 0, 0, 0);
        // R3 invalid retirement ignored, flags held
        step("R3", 0, 6'b111111, 1, 0, 0, 0);
        // R7 trap with enable and no disable
        step("R7", 1, 6'b000100, 1, 0, 0, 0);
        // R10 pulse drops
        step("R10", 0, 0, 0, 0, 0, 0);
        // R6 write underflow-disable only; implies underflow-to-zero
        step("R6", 0, 0, 0, 1, 16'h0800, 0);
        // R7 disabled underflow does not trap, status still set (R2)
        step("R7", 1, 6'b001000, 1, 0, 0, 0);
        // R8 operand-class with result-class together
        step("R8", 1, 6'b110101, 1, 0, 0, 0);
        // R9 clear with simultaneous new trap keeps new bits
        step("R9", 1, 6'b000010, 1, 0, 0, 1);
        // R9 plain clear
        step("R9", 0, 0, 0, 0, 0, 1);
        // R4 write collides with retirement; write wins, reserved bits drop (R5)
        step("R4", 1, 6'b111111, 0, 1, 16'hFFFF, 0);
        step("R5", 0, 0, 0, 1, 16'h0000, 0);

        // random mix, R2 R3 R4 R7 R8 R9 R10
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] f;
            f = 6'($urandom) & 6'($urandom) & 6'($urandom);
            step("R2R7R9", 1'($urandom), f, 1'($urandom),
                 ($urandom % 16) == 0, 16'($urandom), ($urandom % 8) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule